// File: doc/BRIEF.md
# Excess-128 Floating Add/Subtract Unit

This block adds or subtracts two operands held in a 64-bit excess-128 format with a hidden leading bit. Each word has a sign in bit 63, an 8-bit biased exponent in bits 62:55 and an explicit fraction in bits 54:0. A value whose exponent field is zero counts as zero, whatever its fraction holds. A precision input picks between a short form and a long form. The short form uses only the upper 32 bits, which give a 24-bit fraction including the hidden bit. The long form uses the whole word, which gives a 56-bit fraction. A mode input picks between round-to-nearest (add half an LSB) and plain truncation.

An operation starts with a one-cycle `start` pulse while the unit is idle. The unit works through a few states: it aligns the operands, adds or subtracts them, normalizes the result and finally rounds and packs it. It then pulses `done` for one cycle. The packed result, the overflow and underflow flags and the negative and zero indications stay valid until the next operation completes. Two trap-enable inputs decide what happens to an out-of-range exponent. If the matching trap is enabled, the result keeps the low 8 bits of the exponent. If it is not enabled, the result is replaced by zero. Dispatching the trap itself is left to the surrounding logic.

Top module: `fpx_addsub`

## Requirements
- R1: When `sub` is 1, the sign of `op_b` is inverted before the addition, unless the exponent field of `op_b` (bits 62:55) is zero.
- R2: The operand with the larger magnitude (bits 62:0) is treated as the first operand, and the result sign is its sign.
- R3: If the larger operand has a zero exponent, the result is all zeros. If only the smaller operand has a zero exponent, the result is the larger operand unchanged. In both cases no flag is set.
- R4: If the exponent difference is 60 or more, the result is the larger operand unchanged, with no rounding and no flag.
- R5: With unlike signs, if the aligned fractions cancel exactly, the result is all zeros and neither overflow nor underflow is flagged.
- R6: After a subtraction, the fraction is shifted left until the hidden bit is set, and the exponent drops by one for each bit shifted. When the exponents differed by 0 or 1, coarse steps of 24, 12 and 6 bits are tried first.
- R7: With like signs, a carry out of the hidden bit shifts the fraction right by one and raises the exponent by one.
- R8: When `trunc` is 0, one is added just below the result LSB before packing: at fraction bit 2 of the guarded 60-bit fraction in long form, and at bit 34 in short form. A carry out of this addition renormalizes the result. When `trunc` is 1, the extra bits are dropped.
- R9: When `dbl` is 0, bits 31:0 of both operands are treated as zero and bits 31:0 of the result are zero.
- R10: A final exponent above 255 sets `ovf`. The result is then zero if `ovf_trap_on` is 0, and keeps the low 8 exponent bits if it is 1.
- R11: A final exponent of 0 or below sets `unf`. The result is then zero if `unf_trap_on` is 0, and keeps the low 8 exponent bits if it is 1.
- R12: `neg` equals result bit 63, and `zero` is 1 exactly when result bits 62:55 are zero.
- R13: After reset, `busy`, `done` and `result` are 0. A `start` pulse seen while idle makes `busy` rise. A `start` seen while busy is ignored. `done` lasts one cycle, and the outputs hold between completions.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| sub | input | 1 | 1 = subtract `op_b` from `op_a` |
| dbl | input | 1 | 1 = long form, 0 = short form |
| trunc | input | 1 | 1 = truncate, 0 = round |
| ovf_trap_on | input | 1 | Overflow trap enabled (keep the wrapped result) |
| unf_trap_on | input | 1 | Underflow trap enabled (keep the wrapped result) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Packed result |
| ovf | output | 1 | Exponent overflow on the last result |
| unf | output | 1 | Exponent underflow on the last result |
| neg | output | 1 | Result is negative |
| zero | output | 1 | Result exponent is zero |

## Verification
The checker records `dbl` and the two trap enables at the cycle where a `start` is accepted. It assumes these recorded values describe the operation that the next `done` reports. That holds because the unit takes no new `start` while it is busy. The bench changes the mode inputs only together with a `start` pulse given while idle. The one exception is a deliberate `start` given while busy, which must be ignored. The random operands draw exponents that are equal, adjacent or far apart, and now and then zero. This steers the runs into cancellation, deep normalization and the pass-through cases without leaving the legal encoding.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXP_W     = 8;
    localparam int MAN_W     = 55;
    localparam int GRD_W     = 3;
    localparam int WORD_W    = 1 + EXP_W + MAN_W;
    localparam int WIDE_W    = MAN_W + GRD_W + 2;
    localparam int HID_POS   = MAN_W + GRD_W;
    localparam int SGL_LO    = 32;
    localparam int FAR_SHIFT = 60;
    localparam int EXP_S_W   = EXP_W + 2;
    localparam int EXP_MAX   = (1 << EXP_W) - 1;
    localparam int CRS_FIRST = 24;
    localparam int N_CRS     = 3;
    localparam int IDX_W     = 2;

    typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_NORM, ST_ROUND} st_e;
    typedef enum logic [1:0] {PK_ZERO, PK_PASS, PK_WORK} pk_e;

    typedef struct packed {
        st_e                        st;
        logic [WORD_W-1:0]          opa;
        logic [WORD_W-1:0]          opb;
        logic                       dbl;
        logic                       trunc;
        logic                       ovf_on;
        logic                       unf_on;
        logic [WIDE_W-1:0]          frac;
        logic signed [EXP_S_W-1:0]  expo;
        logic                       sign;
        logic                       coarse;
        logic [IDX_W-1:0]           idx;
        logic [WORD_W-1:0]          res;
        logic                       ovf;
        logic                       unf;
        logic                       done;
    } core_t;
endpackage

// File: rtl/fpx_prep.sv
module fpx_prep
    import fpx_pkg::*;
(
    input  logic [WORD_W-1:0]         op_x,
    input  logic [WORD_W-1:0]         op_y,
    output pk_e                       kind,
    output logic [WORD_W-1:0]         pass_val,
    output logic [WIDE_W-1:0]         frac,
    output logic signed [EXP_S_W-1:0] expo,
    output logic                      sign,
    output logic                      unlike,
    output logic                      near
);
    logic [WORD_W-1:0] big, lit;
    logic [EXP_W-1:0]  e_big, e_lit, ediff;
    logic [WIDE_W-1:0] f_big, f_lit, f_dif, f_sum;

    always_comb begin
        big = op_x;
        lit = op_y;
        if (op_x[WORD_W-2:0] < op_y[WORD_W-2:0]) begin
            big = op_y;
            lit = op_x;
        end
        e_big  = big[WORD_W-2 -: EXP_W];
        e_lit  = lit[WORD_W-2 -: EXP_W];
        ediff  = e_big - e_lit;
        f_big  = {2'b01, big[MAN_W-1:0], {GRD_W{1'b0}}};
        f_lit  = {2'b01, lit[MAN_W-1:0], {GRD_W{1'b0}}} >> ediff;
        f_dif  = f_big - f_lit;
        f_sum  = f_big + f_lit;
        unlike = big[WORD_W-1] ^ lit[WORD_W-1];
        near   = (ediff <= EXP_W'(1));
        sign   = big[WORD_W-1];
        pass_val = big;
        expo   = $signed({{(EXP_S_W-EXP_W){1'b0}}, e_big});
        if (unlike) begin
            frac = f_dif;
        end else if (f_sum[WIDE_W-1]) begin
            frac = f_sum >> 1;
            expo = expo + EXP_S_W'(1);
        end else begin
            frac = f_sum;
        end
        if (e_big == '0)
            kind = PK_ZERO;
        else if (e_lit == '0 || ediff >= EXP_W'(FAR_SHIFT))
            kind = PK_PASS;
        else if (unlike && f_dif == '0)
            kind = PK_ZERO;
        else
            kind = PK_WORK;
    end
endmodule

// File: rtl/fpx_norm_step.sv
module fpx_norm_step
    import fpx_pkg::*;
(
    input  logic [WIDE_W-1:0]         frac,
    input  logic signed [EXP_S_W-1:0] expo,
    input  logic                      coarse,
    input  logic [IDX_W-1:0]          idx,
    output logic [WIDE_W-1:0]         frac_n,
    output logic signed [EXP_S_W-1:0] expo_n,
    output logic [IDX_W-1:0]          idx_n,
    output logic                      ready
);
    localparam int N_SLOT = 1 << IDX_W;

    logic [N_SLOT-1:0][WIDE_W-1:0]  cf;
    logic [N_SLOT-1:0][EXP_S_W-1:0] ce;

    for (genvar k = 0; k < N_SLOT; k++) begin : g_crs
        if (k < N_CRS) begin : g_on
            localparam int AMT = CRS_FIRST >> k;
            assign cf[k] = (frac[HID_POS -: AMT] == '0) ? (frac << AMT) : frac;
            assign ce[k] = (frac[HID_POS -: AMT] == '0) ? (expo - EXP_S_W'(AMT)) : expo;
        end else begin : g_off
            assign cf[k] = frac;
            assign ce[k] = expo;
        end
    end

    always_comb begin
        frac_n = frac;
        expo_n = expo;
        idx_n  = idx;
        ready  = 1'b0;
        if (coarse && idx < IDX_W'(N_CRS)) begin
            frac_n = cf[idx];
            expo_n = $signed(ce[idx]);
            idx_n  = idx + IDX_W'(1);
        end else if (frac[HID_POS]) begin
            ready = 1'b1;
        end else begin
            frac_n = frac << 1;
            expo_n = expo - EXP_S_W'(1);
        end
    end
endmodule

// File: rtl/fpx_round.sv
module fpx_round
    import fpx_pkg::*;
(
    input  logic [WIDE_W-1:0]         frac,
    input  logic signed [EXP_S_W-1:0] expo,
    input  logic                      sign,
    input  logic                      dbl,
    input  logic                      trunc,
    input  logic                      ovf_on,
    input  logic                      unf_on,
    output logic [WORD_W-1:0]         res,
    output logic                      ovf,
    output logic                      unf
);
    localparam logic signed [EXP_S_W-1:0] E_TOP = EXP_S_W'(EXP_MAX);
    localparam logic signed [EXP_S_W-1:0] E_ONE = EXP_S_W'(1);

    logic [WIDE_W-1:0]         inc, f_a, f_r;
    logic signed [EXP_S_W-1:0] e_r;

    always_comb begin
        inc = dbl ? (WIDE_W'(1) << (GRD_W - 1)) : (WIDE_W'(1) << (GRD_W + SGL_LO - 1));
        f_a = trunc ? frac : frac + inc;
        f_r = f_a;
        e_r = expo;
        if (f_a[WIDE_W-1]) begin
            f_r = f_a >> 1;
            e_r = expo + EXP_S_W'(1);
        end
        res = {sign, e_r[EXP_W-1:0], f_r[HID_POS-1 -: MAN_W]};
        if (!dbl)
            res[SGL_LO-1:0] = '0;
        ovf = (e_r > E_TOP);
        unf = (e_r < E_ONE);
        if ((ovf && !ovf_on) || (unf && !unf_on))
            res = '0;
    end
endmodule

// File: rtl/fpx_addsub.sv
module fpx_addsub
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       op_a,
    input  logic [63:0]       op_b,
    input  logic              sub,
    input  logic              dbl,
    input  logic              trunc,
    input  logic              ovf_trap_on,
    input  logic              unf_trap_on,
    output logic              busy,
    output logic              done,
    output logic [63:0]       result,
    output logic              ovf,
    output logic              unf,
    output logic              neg,
    output logic              zero
);
    core_t q, d;

    pk_e                       p_kind;
    logic [WORD_W-1:0]         p_pass;
    logic [WIDE_W-1:0]         p_frac;
    logic signed [EXP_S_W-1:0] p_expo;
    logic                      p_sign, p_unlike, p_near;

    logic [WIDE_W-1:0]         n_frac;
    logic signed [EXP_S_W-1:0] n_expo;
    logic [IDX_W-1:0]          n_idx;
    logic                      n_ready;

    logic [WORD_W-1:0]         r_res;
    logic                      r_ovf, r_unf;
    logic [WORD_W-1:0]         a_m, b_m;

    fpx_prep u_prep (
        .op_x(q.opa), .op_y(q.opb), .kind(p_kind), .pass_val(p_pass),
        .frac(p_frac), .expo(p_expo), .sign(p_sign), .unlike(p_unlike), .near(p_near)
    );

    fpx_norm_step u_norm (
        .frac(q.frac), .expo(q.expo), .coarse(q.coarse), .idx(q.idx),
        .frac_n(n_frac), .expo_n(n_expo), .idx_n(n_idx), .ready(n_ready)
    );

    fpx_round u_round (
        .frac(q.frac), .expo(q.expo), .sign(q.sign), .dbl(q.dbl), .trunc(q.trunc),
        .ovf_on(q.ovf_on), .unf_on(q.unf_on), .res(r_res), .ovf(r_ovf), .unf(r_unf)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        a_m    = op_a;
        b_m    = op_b;
        if (!dbl) begin
            a_m[SGL_LO-1:0] = '0;
            b_m[SGL_LO-1:0] = '0;
        end
        if (sub && b_m[WORD_W-2 -: EXP_W] != '0)
            b_m[WORD_W-1] = ~b_m[WORD_W-1];
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.opa    = a_m;
                    d.opb    = b_m;
                    d.dbl    = dbl;
                    d.trunc  = trunc;
                    d.ovf_on = ovf_trap_on;
                    d.unf_on = unf_trap_on;
                    d.st     = ST_PREP;
                end
            end
            ST_PREP: begin
                case (p_kind)
                    PK_ZERO, PK_PASS: begin
                        d.res  = (p_kind == PK_PASS) ? p_pass : '0;
                        d.ovf  = 1'b0;
                        d.unf  = 1'b0;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end
                    default: begin
                        d.frac   = p_frac;
                        d.expo   = p_expo;
                        d.sign   = p_sign;
                        d.coarse = p_unlike && p_near;
                        d.idx    = '0;
                        d.st     = p_unlike ? ST_NORM : ST_ROUND;
                    end
                endcase
            end
            ST_NORM: begin
                d.frac = n_frac;
                d.expo = n_expo;
                d.idx  = n_idx;
                if (n_ready)
                    d.st = ST_ROUND;
            end
            ST_ROUND: begin
                d.res  = r_res;
                d.ovf  = r_ovf;
                d.unf  = r_unf;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign busy   = (q.st != ST_IDLE);
    assign done   = q.done;
    assign result = q.res;
    assign ovf    = q.ovf;
    assign unf    = q.unf;
    assign neg    = q.res[WORD_W-1];
    assign zero   = (q.res[WORD_W-2 -: EXP_W] == '0);
endmodule

// File: rtl/fpx_addsub_chk.sv
module fpx_addsub_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        dbl,
    input logic        ovf_trap_on,
    input logic        unf_trap_on,
    input logic        busy,
    input logic        done,
    input logic [63:0] result,
    input logic        ovf,
    input logic        unf,
    input logic        zero
);
    localparam int CNT_W   = 8;
    localparam int MAX_LAT = 80;

    logic             cap_dbl, cap_ovf_on, cap_unf_on;
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_dbl    <= 1'b0;
            cap_ovf_on <= 1'b0;
            cap_unf_on <= 1'b0;
            busy_cnt   <= '0;
        end else begin
            if (start && !busy) begin
                cap_dbl    <= dbl;
                cap_ovf_on <= ovf_trap_on;
                cap_unf_on <= unf_trap_on;
            end
            busy_cnt <= busy ? busy_cnt + CNT_W'(1) : '0;
        end
    end

    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r13_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
    a_r5_true_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero && !ovf && !unf) |-> (result == 64'd0));
    a_r10_ovf_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf && !cap_ovf_on) |-> (result == 64'd0));
    a_r11_unf_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unf && !cap_unf_on) |-> (result == 64'd0));
    a_r9_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_dbl) |-> (result[31:0] == 32'd0));
    a_r10_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(ovf && unf));
    a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt < CNT_W'(MAX_LAT));
endmodule

bind fpx_addsub fpx_addsub_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dbl(dbl),
    .ovf_trap_on(ovf_trap_on), .unf_trap_on(unf_trap_on),
    .busy(busy), .done(done), .result(result), .ovf(ovf), .unf(unf), .zero(zero)
);

// File: tb/fpx_addsub_tb_top.sv
module fpx_addsub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        sub = 1'b0, dbl = 1'b0, trunc = 1'b0, ovf_trap_on = 1'b0, unf_trap_on = 1'b0;
    logic        busy, done, ovf, unf, neg, zero;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    fpx_addsub dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .sub(sub), .dbl(dbl), .trunc(trunc), .ovf_trap_on(ovf_trap_on),
        .unf_trap_on(unf_trap_on), .busy(busy), .done(done), .result(result),
        .ovf(ovf), .unf(unf), .neg(neg), .zero(zero)
    );

    function automatic logic [65:0] ref_op(input logic [63:0] a_in, b_in,
                                           input logic s, dd, tt, ov, un);
        logic [63:0] a, b, t, res;
        logic [59:0] fa, fb, f;
        int ea, eb, e;
        logic vo, vu;
        a = a_in; b = b_in;
        if (!dd) begin a[31:0] = '0; b[31:0] = '0; end
        if (s && b[62:55] != 0) b[63] = ~b[63];
        if (a[62:0] < b[62:0]) begin t = a; a = b; b = t; end
        ea = int'(a[62:55]); eb = int'(b[62:55]);
        if (ea == 0) return 66'd0;
        if (eb == 0 || ea - eb >= 60) return {a, 2'b00};
        fa = {2'b01, a[54:0], 3'b000};
        fb = {2'b01, b[54:0], 3'b000};
        fb = fb >> (ea - eb);
        e = ea;
        if (a[63] != b[63]) begin
            f = fa - fb;
            if (f == 0) return 66'd0;
            while (!f[58]) begin f = f << 1; e--; end
        end else begin
            f = fa + fb;
            if (f[59]) begin f = f >> 1; e++; end
        end
        if (!tt) begin
            f = f + (dd ? 60'd4 : 60'h4_0000_0000);
            if (f[59]) begin f = f >> 1; e++; end
        end
        res = {a[63], e[7:0], f[57:3]};
        if (!dd) res[31:0] = '0;
        vo = (e > 255);
        vu = (e <= 0);
        if ((vo && !ov) || (vu && !un)) res = '0;
        return {res, vo, vu};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL R13 no done pulse actual=0 expected=1");
        end
    endtask

    task automatic run_op(input string req, input logic [63:0] a, b,
                          input logic s, dd, tt, ov, un);
        logic [65:0] e;
        e = ref_op(a, b, s, dd, tt, ov, un);
        @(negedge clk);
        op_a = a; op_b = b; sub = s; dbl = dd; trunc = tt;
        ovf_trap_on = ov; unf_trap_on = un; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(req, result, e[65:2]);
        chk("R10", {63'd0, ovf}, {63'd0, e[1]});
        chk("R11", {63'd0, unf}, {63'd0, e[0]});
        chk("R12", {62'd0, neg, zero}, {62'd0, e[65], e[64:57] == 8'd0});
    endtask

    initial begin
        #(4 * 150000);
        checks++; fails++;
        $display("FAIL R13 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [65:0] e1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R13", {62'd0, busy, done}, 64'd0);
        chk("R13", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", {62'd0, busy, done}, 64'd0);

        // R8: half-LSB rounding in short form
        run_op("R8", 64'h4080_0000_0000_0000, 64'h3480_0000_0000_0000, 0, 0, 0, 0, 0);
        chk("R8", result, 64'h4080_0001_0000_0000);
        run_op("R8", 64'h4080_0000_0000_0000, 64'h3480_0000_0000_0000, 0, 0, 1, 0, 0);
        chk("R8", result, 64'h4080_0000_0000_0000);
        // R1, R2: 1 - 2 gives -1
        run_op("R1", 64'h4080_0000_0000_0000, 64'h4100_0000_0000_0000, 1, 1, 0, 0, 0);
        chk("R2", result, 64'hC080_0000_0000_0000);
        // R5: exact cancellation
        run_op("R5", 64'h4123_4567_89AB_CDEF, 64'h4123_4567_89AB_CDEF, 1, 1, 0, 0, 0);
        chk("R5", result, 64'd0);
        // R3: zero-exponent operands
        run_op("R3", 64'h807F_FFFF_0000_1234, 64'h0000_0000_0000_0000, 0, 1, 0, 0, 0);
        chk("R3", result, 64'd0);
        run_op("R3", 64'h4080_0000_0000_0005, 64'h807F_0000_1111_0000, 1, 1, 0, 0, 0);
        chk("R3", result, 64'h4080_0000_0000_0005);
        // R4: exponent gap of 60
        run_op("R4", 64'h4080_0000_0000_0001, 64'h2280_0000_0000_0000, 0, 1, 0, 0, 0);
        chk("R4", result, 64'h4080_0000_0000_0001);
        // R9, R7: low halves ignored, 1 + 1 carries to 2
        run_op("R9", 64'h4080_0000_FFFF_FFFF, 64'h4080_0000_1234_5678, 0, 0, 0, 0, 0);
        chk("R7", result, 64'h4100_0000_0000_0000);
        // R10: overflow, both trap settings
        run_op("R10", 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 0, 1, 0, 0, 0);
        chk("R10", {63'd0, ovf}, 64'd1);
        run_op("R10", 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 0, 1, 0, 1, 0);
        // R11: underflow, both trap settings
        run_op("R11", 64'h0080_0000_0000_0001, 64'h0080_0000_0000_0000, 1, 1, 0, 0, 0);
        chk("R11", {63'd0, unf}, 64'd1);
        run_op("R11", 64'h0080_0000_0000_0001, 64'h0080_0000_0000_0000, 1, 1, 1, 0, 1);
        // R6: deep cancellation with coarse steps
        run_op("R6", 64'h4080_0000_0000_0100, 64'h4080_0000_0000_0000, 1, 1, 0, 0, 0);
        run_op("R6", 64'h4555_5555_0000_0000, 64'h4555_5554_0000_0000, 1, 0, 0, 0, 0);

        // R13: start while busy is ignored
        e1 = ref_op(64'h4080_0000_0000_0000, 64'h4100_0000_0000_0000, 0, 1, 0, 0, 0);
        @(negedge clk);
        op_a = 64'h4080_0000_0000_0000; op_b = 64'h4100_0000_0000_0000;
        sub = 0; dbl = 1; trunc = 0; start = 1'b1;
        @(negedge clk);
        chk("R13", {63'd0, busy}, 64'd1);
        op_a = 64'h5000_0000_0000_0000; op_b = 64'h5000_0000_0000_0000; sub = 1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R13", result, e1[65:2]);
        @(negedge clk);
        chk("R13", {63'd0, done}, 64'd0);
        chk("R13", result, e1[65:2]);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  ea, eb;
            logic [54:0] fa, fb;
            logic [63:0] a, b;
            ea = 8'($urandom_range(1, 254));
            if ($urandom_range(0, 15) == 0) ea = 8'd0;
            case ($urandom_range(0, 3))
                0: eb = ea;
                1: eb = ea + 8'd1;
                2: eb = 8'($urandom_range(0, 255));
                default: eb = (ea > 8'd70) ? ea - 8'($urandom_range(0, 70)) : 8'd0;
            endcase
            fa = 55'({$urandom, $urandom});
            fb = ($urandom_range(0, 2) == 0) ? fa ^ 55'($urandom_range(0, 4095)) : 55'({$urandom, $urandom});
            a = {1'($urandom), ea, fa};
            b = {1'($urandom), eb, fb};
            run_op((i % 2 == 0) ? "R6" : "R2", a, b, 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule